// File: doc/BRIEF.md
# Control-Flow Signature Checker

This block watches a program walk through its basic blocks and catches branches that the program graph does not allow. Every basic block has a fixed signature that is chosen before the program runs. Each block also has a signature difference, which is the XOR of its predecessor's signature and its own. The checker keeps a running signature. Each time software enters a block, it presents that block's expected signature, its difference and an adjusting value. The checker folds the difference and the adjusting value into the running signature with XOR, then compares the result with the expected signature.

A block can have several legal predecessors. Its difference is then computed from one chosen predecessor. The adjusting value is zero on the path from that chosen predecessor. On a path from any other predecessor it is the XOR of that predecessor's signature and the chosen one's, so every legal path lands on the same signature. A start pulse loads the entry block's signature and opens a new run. A mismatch raises a sticky error flag and records the expected signature of the first block that failed. Recovery is left to the surrounding system.

Top module: `cfsig_checker`

## Requirements
- R1: While `rst` is high at a clock edge, `run_sig`, `err_flag`, `err_id`, `check_done` and `check_fail` become zero at that edge.
- R2: A clock edge with `start` high loads `run_sig` with `start_sig` and clears `err_flag` and `err_id` to zero.
- R3: A clock edge with `entry_valid` high and `start` low sets `run_sig` to the old `run_sig` XOR `entry_diff` XOR `entry_adj`.
- R4: `check_done` is high for exactly the cycle after each accepted strobe. Strobes on consecutive cycles give consecutive done cycles, and `check_done` is low in every other cycle.
- R5: `check_fail` is high together with `check_done` exactly when the updated running signature differs from the `entry_sig` presented with that strobe.
- R6: `err_flag` goes high in the cycle that a failing check completes. It then stays high until the next start, whatever later checks report.
- R7: `err_id` holds the `entry_sig` of the first failing block after a start. Later failures leave it unchanged.
- R8: On a failing check, `run_sig` still takes the XOR result and not the expected signature, so later checks work from the corrupted value.
- R9: A block with several predecessors passes when entered from its chosen predecessor with `entry_adj` zero. It also passes when entered from another legal predecessor with `entry_adj` equal to that predecessor's signature XOR the chosen one's.
- R10: When `start` and `entry_valid` are high at the same edge, the start takes effect and the strobe is ignored: no `check_done` follows, and `run_sig` equals `start_sig`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Program-start pulse |
| start_sig | input | SIG_W | Signature of the entry block, loaded at start |
| entry_valid | input | 1 | Single-cycle block-entry strobe |
| entry_sig | input | SIG_W | Expected signature of the block being entered |
| entry_diff | input | SIG_W | Signature difference of the block being entered |
| entry_adj | input | SIG_W | Adjusting value for this path, zero when none is needed |
| run_sig | output | SIG_W | Running signature register |
| check_done | output | 1 | Pulse in the cycle after an accepted strobe |
| check_fail | output | 1 | Mismatch result, valid with `check_done` |
| err_flag | output | 1 | Sticky illegal-branch flag |
| err_id | output | SIG_W | Expected signature of the first failing block |

## Verification
The bench drives the XOR chain through four kinds of path:
- A straight legal chain shows that the fold and the compare agree when the graph is followed.
- Both legal paths into a fan-in node are tried, one with a zero adjusting value and one with a non-zero adjusting value. Only a correct adjusting term lets both pass.
- An illegal jump into a block whose difference belongs to another predecessor must fail, and the corrupted signature that results must make the following legal-looking entry fail too. This separates a design that keeps the XOR result from one that resynchronises to the expected value.
- Back-to-back strobes and a strobe that coincides with start show the pulse timing and the priority of start.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;

  // Operation selected for the current cycle; start outranks a block entry.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_START = 2'd1,
    OP_ENTER = 2'd2
  } cf_op_e;

  localparam int unsigned DEF_SIG_W = 16;

endpackage

// File: rtl/cfsig_next.sv
module cfsig_next #(
  parameter int unsigned SIG_W = 16
) (
  input  logic [SIG_W-1:0] run_q,
  input  logic [SIG_W-1:0] diff,
  input  logic [SIG_W-1:0] adj,
  input  logic [SIG_W-1:0] expect_sig,
  output logic [SIG_W-1:0] sum,
  output logic             mismatch
);

  always_comb begin
    sum      = run_q ^ diff ^ adj;
    mismatch = (sum != expect_sig);
  end

endmodule

// File: rtl/cfsig_track.sv
module cfsig_track
  import cfsig_pkg::*;
#(
  parameter int unsigned SIG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cf_op_e           op,
  input  logic [SIG_W-1:0] start_sig,
  input  logic [SIG_W-1:0] sum,
  output logic [SIG_W-1:0] run_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else begin
      unique case (op)
        OP_START: run_q <= start_sig;
        OP_ENTER: run_q <= sum;
        default:  run_q <= run_q;
      endcase
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_START) |=> (run_q == $past(start_sig)));

endmodule

// File: rtl/cfsig_errlog.sv
module cfsig_errlog
  import cfsig_pkg::*;
#(
  parameter int unsigned SIG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cf_op_e           op,
  input  logic             mismatch,
  input  logic [SIG_W-1:0] expect_sig,
  output logic             done_q,
  output logic             fail_q,
  output logic             flag_q,
  output logic [SIG_W-1:0] id_q
);

  logic first_fail;

  always_comb first_fail = (op == OP_ENTER) && mismatch && !flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      flag_q <= 1'b0;
      id_q   <= '0;
    end else begin
      done_q <= (op == OP_ENTER);
      fail_q <= (op == OP_ENTER) && mismatch;
      if (op == OP_START) begin
        flag_q <= 1'b0;
        id_q   <= '0;
      end else if (first_fail) begin
        flag_q <= 1'b1;
        id_q   <= expect_sig;
      end
    end
  end

  // R5
  fail_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    fail_q |-> done_q);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && op != OP_START) |=> flag_q);

  // R6
  fail_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fail_q |-> flag_q);

  // R7
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && op != OP_START) |=> $stable(id_q));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_START) |=> (!flag_q && id_q == '0));

endmodule

// File: rtl/cfsig_checker.sv
module cfsig_checker
  import cfsig_pkg::*;
#(
  parameter int unsigned SIG_W = DEF_SIG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SIG_W-1:0] start_sig,
  input  logic             entry_valid,
  input  logic [SIG_W-1:0] entry_sig,
  input  logic [SIG_W-1:0] entry_diff,
  input  logic [SIG_W-1:0] entry_adj,
  output logic [SIG_W-1:0] run_sig,
  output logic             check_done,
  output logic             check_fail,
  output logic             err_flag,
  output logic [SIG_W-1:0] err_id
);

  cf_op_e           op;
  logic [SIG_W-1:0] sum;
  logic             mismatch;

  // Start has priority over a block entry in the same cycle.
  always_comb begin
    if (start)            op = OP_START;
    else if (entry_valid) op = OP_ENTER;
    else                  op = OP_IDLE;
  end

  cfsig_next #(.SIG_W(SIG_W)) u_next (
    .run_q      (run_sig),
    .diff       (entry_diff),
    .adj        (entry_adj),
    .expect_sig (entry_sig),
    .sum        (sum),
    .mismatch   (mismatch)
  );

  cfsig_track #(.SIG_W(SIG_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .start_sig (start_sig),
    .sum       (sum),
    .run_q     (run_sig)
  );

  cfsig_errlog #(.SIG_W(SIG_W)) u_errlog (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .mismatch   (mismatch),
    .expect_sig (entry_sig),
    .done_q     (check_done),
    .fail_q     (check_fail),
    .flag_q     (err_flag),
    .id_q       (err_id)
  );

  // R3
  xor_fold_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && !start) |=>
      (run_sig == ($past(run_sig) ^ $past(entry_diff) ^ $past(entry_adj))));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && !start) |=> check_done);

  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(entry_valid && !start) |=> !check_done);

  // R5
  fail_result_chk: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && !start) |=> (check_fail == (run_sig != $past(entry_sig))));

endmodule

// File: tb/cfsig_checker_test.sv
module cfsig_checker_test;

  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst, start, entry_valid;
  logic [W-1:0] start_sig, entry_sig, entry_diff, entry_adj;
  logic [W-1:0] run_sig, err_id;
  logic         check_done, check_fail, err_flag;

  int checks = 0;
  int errors = 0;

  // bench model, updated from the requirements
  logic [W-1:0] m_run;
  logic         m_flag;
  logic [W-1:0] m_id;

  always #5 clk = ~clk;

  cfsig_checker #(.SIG_W(W)) uut (
    .clk, .rst, .start, .start_sig, .entry_valid, .entry_sig,
    .entry_diff, .entry_adj, .run_sig, .check_done, .check_fail,
    .err_flag, .err_id
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk({req, " run_sig"}, 32'(run_sig), 32'(m_run));
    chk({req, " err_flag"}, 32'(err_flag), 32'(m_flag));
    chk({req, " err_id"}, 32'(err_id), 32'(m_id));
  endtask

  task automatic do_start(input logic [W-1:0] s);
    @(negedge clk);
    start = 1'b1; start_sig = s;
    @(negedge clk);
    start = 1'b0;
    m_run = s; m_flag = 1'b0; m_id = '0;
    check_state("R2 start");
  endtask

  // One strobe, result checked in the following cycle.
  task automatic enter(input string req, input logic [W-1:0] sig,
                       input logic [W-1:0] diff, input logic [W-1:0] adj);
    logic [W-1:0] nxt;
    logic         bad;
    @(negedge clk);
    entry_valid = 1'b1; entry_sig = sig; entry_diff = diff; entry_adj = adj;
    @(negedge clk);
    entry_valid = 1'b0;
    nxt = m_run ^ diff ^ adj;
    bad = (nxt != sig);
    if (bad && !m_flag) begin m_flag = 1'b1; m_id = sig; end
    m_run = nxt;
    chk({req, " R4 check_done"}, 32'(check_done), 32'd1);
    chk({req, " R5 check_fail"}, 32'(check_fail), 32'(bad));
    check_state({req, " R3"});
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; entry_valid = 1'b0;
    start_sig = '0; entry_sig = '0; entry_diff = '0; entry_adj = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_run = '0; m_flag = 1'b0; m_id = '0;
    chk("R1 check_done", 32'(check_done), 32'd0);
    chk("R1 check_fail", 32'(check_fail), 32'd0);
    check_state("R1 reset");
  endtask

  task automatic t_legal_chain;
    do_start(16'h1111);
    enter("legal s2", 16'h2222, 16'h1111 ^ 16'h2222, '0);
    enter("legal s3", 16'h4C4C, 16'h2222 ^ 16'h4C4C, '0);
    @(negedge clk);
    chk("R4 idle done low", 32'(check_done), 32'd0);
  endtask

  task automatic t_fanin;
    // s5 has predecessors s1 (chosen) and s3
    do_start(16'h0A01);
    enter("R9 from chosen", 16'h5E05, 16'h0A01 ^ 16'h5E05, '0);
    do_start(16'h3303);
    enter("R9 from other", 16'h5E05, 16'h0A01 ^ 16'h5E05, 16'h0A01 ^ 16'h3303);
    chk("R9 pass", 32'(err_flag), 32'd0);
  endtask

  task automatic t_illegal;
    do_start(16'h0A01);
    // jump into s4 whose difference is built from s3
    enter("R5 illegal", 16'h7707, 16'h3303 ^ 16'h7707, '0);
    chk("R6 flag set", 32'(err_flag), 32'd1);
    chk("R7 id first", 32'(err_id), 32'h7707);
    chk("R8 corrupted", 32'(run_sig), 32'(16'h0A01 ^ 16'h3303 ^ 16'h7707));
    // s6 follows s4 legally, but the state is corrupted
    enter("R8 follow-on", 16'h9909, 16'h7707 ^ 16'h9909, '0);
    chk("R8 follow-on fails", 32'(check_fail), 32'd1);
    chk("R7 id kept", 32'(err_id), 32'h7707);
    // a passing check does not clear the flag
    enter("R6 pass after fail", m_run ^ 16'h0042, 16'h0042, '0);
    chk("R6 still set", 32'(err_flag), 32'd1);
    do_start(16'h1234);
    chk("R2 flag cleared", 32'(err_flag), 32'd0);
  endtask

  task automatic t_back_to_back;
    do_start(16'hAAAA);
    @(negedge clk);
    entry_valid = 1'b1; entry_sig = 16'hBBBB;
    entry_diff = 16'hAAAA ^ 16'hBBBB; entry_adj = '0;
    @(negedge clk);
    chk("R4 b2b first", 32'(check_done), 32'd1);
    chk("R5 b2b first", 32'(check_fail), 32'd0);
    entry_sig = 16'hCCCC; entry_diff = 16'hBBBB ^ 16'hCCCC;
    @(negedge clk);
    entry_valid = 1'b0;
    chk("R4 b2b second", 32'(check_done), 32'd1);
    chk("R3 b2b run", 32'(run_sig), 32'hCCCC);
    @(negedge clk);
    chk("R4 b2b end", 32'(check_done), 32'd0);
    m_run = 16'hCCCC;
  endtask

  task automatic t_start_priority;
    @(negedge clk);
    start = 1'b1; start_sig = 16'h5555;
    entry_valid = 1'b1; entry_sig = 16'h0001; entry_diff = 16'h00FF; entry_adj = '0;
    @(negedge clk);
    start = 1'b0; entry_valid = 1'b0;
    chk("R10 no done", 32'(check_done), 32'd0);
    chk("R10 run", 32'(run_sig), 32'h5555);
    chk("R10 flag", 32'(err_flag), 32'd0);
  endtask

  initial begin
    t_reset();
    t_legal_chain();
    t_fanin();
    t_illegal();
    t_back_to_back();
    t_start_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule